// File: doc/BRIEF.md
# Hashed MAC Address Lookup Table

This block keeps a table of 48-bit Ethernet addresses, each stored with a small data word such as an output port number. A key is hashed with a 16-bit CRC, and the low bits of the CRC select a bucket. Every bucket holds a fixed number of ways. A lookup reads the ways of its bucket one per clock cycle. It stops at the first valid entry whose full key matches, or it reports a miss once the bucket has been read to the end. The time a lookup takes therefore depends on where the key sits in its bucket.

A second request port learns addresses. It walks the same bucket and acts in one of three ways:
- If the key is already present, it rewrites that entry's data.
- Otherwise it places the key in the lowest free way.
- If the bucket has no free way, it rejects the key and flags the bucket as full.

Both request ports use a valid/ready handshake. Only one operation is in progress at a time, and lookups win when both ports request in the same cycle.

Top module: `mac_hash_table`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` and `ins_ready` are high, and `rsp_valid`, `ins_done` and `ins_full` are low.
- R2: The bucket of a key is the low IDX_W bits of a CRC-16 over the 48 key bits. The CRC uses polynomial 0x1021 and start value 0xFFFF. Key bits are fed from bit 47 down to bit 0, with no reflection and no final inversion. Keys with equal bucket bits share the WAYS entries of one bucket.
- R3: A lookup probes ways 0 upward, one per cycle. If the key is valid in way w, `rsp_valid` pulses w+1 cycles after the accepting edge, with `rsp_hit`=1 and the stored data on `rsp_data`.
- R4: A lookup with no matching valid entry answers WAYS cycles after acceptance, with `rsp_hit`=0 and `rsp_data`=0.
- R5: Inserting a key that is absent writes it into the lowest-numbered invalid way of its bucket. `ins_done` pulses WAYS cycles after acceptance, with `ins_full`=0.
- R6: Inserting a key already present in way w replaces only that entry's data. `ins_done` pulses w+1 cycles after acceptance, with `ins_full`=0, and no second copy of the key is created.
- R7: Inserting an absent key into a bucket whose ways are all valid changes no entry. `ins_done` pulses WAYS cycles after acceptance, with `ins_full`=1.
- R8: While an operation is in progress both ready outputs are low. In an idle cycle, `ins_ready` is low whenever `lk_valid` is high, so a lookup is always accepted first.
- R9: `rsp_valid` and `ins_done` are each one-cycle pulses, and they are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_key | input | 48 | Address to look up |
| rsp_valid | output | 1 | One-cycle lookup result strobe |
| rsp_hit | output | 1 | Lookup found the key |
| rsp_data | output | DATA_W | Data of the matching entry, zero on miss |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request accepted when high with ins_valid |
| ins_key | input | 48 | Address to learn |
| ins_data | input | DATA_W | Data to store with the address |
| ins_done | output | 1 | One-cycle insert completion strobe |
| ins_full | output | 1 | With ins_done: insert rejected, bucket full |

## Verification
The bench keeps the defaults: DATA_W=8, IDX_W=4 (16 buckets) and WAYS=4. With these values the bench's own CRC model can quickly find five addresses that fall into one bucket and five more that fall into another. That brings every way position within reach, along with the full-bucket rejection and overwrites of keys in a full bucket. Latency is compared for every result, so a wrong hash, a wrong probe order or a misplaced insert shows up as a changed cycle count or a missing hit.

// File: rtl/mac_hash_table.sv
`timescale 1ns/1ps
module mac_hash_table #(
  parameter int KEY_W  = 48,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [DATA_W-1:0] ins_data,
  output logic              ins_done,
  output logic              ins_full
);
  localparam int BUCKETS = 1 << IDX_W;
  localparam int ENTRIES = BUCKETS * WAYS;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_INS} state_t;

  function automatic logic [IDX_W-1:0] bucket_of(input logic [KEY_W-1:0] k);
    logic [15:0] c;
    logic        fb;
    c = 16'hFFFF;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      fb = c[15] ^ k[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c[IDX_W-1:0];
  endfunction

  logic [KEY_W-1:0]  tbl_key  [ENTRIES];
  logic [DATA_W-1:0] tbl_data [ENTRIES];
  logic [ENTRIES-1:0] tbl_vld;

  state_t            state;
  logic [KEY_W-1:0]  op_key;
  logic [DATA_W-1:0] op_data;
  logic [IDX_W-1:0]  op_bkt;
  logic [WAY_W-1:0]  way;
  logic              free_ok;
  logic [WAY_W-1:0]  free_way;

  logic [KEY_W-1:0]  sel_key;
  logic [IDX_W-1:0]  new_bkt;
  logic [SLOT_W-1:0] base, slot, free_slot, wr_slot;
  logic              probe_hit, last, free_now, use_free, wr_en, wr_new;

  assign lk_ready  = (state == S_IDLE);
  assign ins_ready = (state == S_IDLE) && !lk_valid;

  assign sel_key   = lk_valid ? lk_key : ins_key;
  assign new_bkt   = bucket_of(sel_key);
  assign base      = SLOT_W'(op_bkt) * SLOT_W'(WAYS);
  assign slot      = base + SLOT_W'(way);
  assign free_slot = base + SLOT_W'(free_way);
  assign probe_hit = tbl_vld[slot] && (tbl_key[slot] == op_key);
  assign last      = (way == WAY_W'(WAYS - 1));
  assign free_now  = !tbl_vld[slot];
  assign use_free  = free_ok || free_now;

  always_comb begin
    wr_en   = 1'b0;
    wr_new  = 1'b0;
    wr_slot = slot;
    if (state == S_INS) begin
      if (probe_hit) begin
        wr_en = 1'b1;
      end else if (last && use_free) begin
        wr_en   = 1'b1;
        wr_new  = 1'b1;
        wr_slot = free_ok ? free_slot : slot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tbl_data[wr_slot] <= op_data;
      if (wr_new) tbl_key[wr_slot] <= op_key;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                tbl_vld          <= '0;
    else if (wr_en && wr_new)  tbl_vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_key    <= '0;
      op_data   <= '0;
      op_bkt    <= '0;
      way       <= '0;
      free_ok   <= 1'b0;
      free_way  <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      ins_done  <= 1'b0;
      ins_full  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ins_done  <= 1'b0;
      ins_full  <= 1'b0;
      case (state)
        S_IDLE: begin
          way     <= '0;
          free_ok <= 1'b0;
          op_bkt  <= new_bkt;
          if (lk_valid) begin
            op_key <= lk_key;
            state  <= S_LOOK;
          end else if (ins_valid) begin
            op_key  <= ins_key;
            op_data <= ins_data;
            state   <= S_INS;
          end
        end
        S_LOOK: begin
          if (probe_hit || last) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= probe_hit;
            rsp_data  <= probe_hit ? tbl_data[slot] : '0;
            state     <= S_IDLE;
          end else begin
            way <= way + WAY_W'(1);
          end
        end
        S_INS: begin
          if (probe_hit || last) begin
            ins_done <= 1'b1;
            ins_full <= !probe_hit && !use_free;
            state    <= S_IDLE;
          end else begin
            if (free_now && !free_ok) begin
              free_ok  <= 1'b1;
              free_way <= way;
            end
            way <= way + WAY_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_hash_table_chk.sv
`timescale 1ns/1ps
module mac_hash_table_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              ins_done,
  input logic              ins_full
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ins_done |=> !ins_done); // R9
  AST_NO_DUAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_valid && ins_done)); // R9
  AST_BUSY_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_ready) |=> (!lk_ready && !ins_ready)); // R8
  AST_BUSY_AFTER_INSERT: assert property (@(posedge clk) disable iff (!rst_n) (ins_valid && ins_ready) |=> (!lk_ready && !ins_ready)); // R8
  AST_LOOKUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |-> !ins_ready); // R8
  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_data == '0)); // R4
  AST_FULL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) ins_full |-> ins_done); // R7
endmodule

bind mac_hash_table mac_hash_table_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .ins_valid(ins_valid), .ins_ready(ins_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_data(rsp_data), .ins_done(ins_done), .ins_full(ins_full)
);

// File: tb/mac_hash_table_test.sv
`timescale 1ns/1ps
module mac_hash_table_test;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;
  localparam int WAYS   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0;
  logic              lk_ready;
  logic [47:0]       lk_key = '0;
  logic              rsp_valid, rsp_hit;
  logic [DATA_W-1:0] rsp_data;
  logic              ins_valid = 1'b0;
  logic              ins_ready;
  logic [47:0]       ins_key = '0;
  logic [DATA_W-1:0] ins_data = '0;
  logic              ins_done, ins_full;

  always #10 clk = ~clk;

  mac_hash_table #(.KEY_W(48), .DATA_W(DATA_W), .IDX_W(IDX_W), .WAYS(WAYS)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_key(ins_key), .ins_data(ins_data),
    .ins_done(ins_done), .ins_full(ins_full)
  );

  typedef struct {
    bit          is_ins;
    bit          flag;
    logic [7:0]  data;
    int          lat;
    int          acc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [IDX_W-1:0] hash_bkt(input logic [47:0] k);
    logic [15:0] c;
    logic        fb;
    c = 16'hFFFF;
    for (int i = 47; i >= 0; i--) begin
      fb = c[15] ^ k[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c[IDX_W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (rsp_valid || ins_done)) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected result strobe", 1, 0);
      end else begin
        exp_t e;
        int   lat;
        e   = q.pop_front();
        lat = cyc - e.acc;
        if (e.is_ins) begin
          check(ins_done && !rsp_valid && ins_full == e.flag && lat == e.lat, e.req,
                "insert full/latency", int'(ins_full) * 1000 + lat, int'(e.flag) * 1000 + e.lat);
        end else begin
          check(rsp_valid && !ins_done && rsp_hit == e.flag && rsp_data == e.data && lat == e.lat, e.req,
                "lookup hit/data/latency", int'(rsp_hit) * 100000 + int'(rsp_data) * 100 + lat,
                int'(e.flag) * 100000 + int'(e.data) * 100 + e.lat);
        end
      end
    end
  end

  task automatic do_lookup(input logic [47:0] k, input bit hit, input logic [7:0] d, input int lat, input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_key   = k;
    while (!lk_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    e.is_ins = 1'b0; e.flag = hit; e.data = d; e.lat = lat; e.acc = cyc; e.req = req;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic do_insert(input logic [47:0] k, input logic [7:0] d, input bit full, input int lat, input string req);
    exp_t e;
    @(negedge clk);
    ins_valid = 1'b1;
    ins_key   = k;
    ins_data  = d;
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    e.is_ins = 1'b1; e.flag = full; e.data = '0; e.lat = lat; e.acc = cyc; e.req = req;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finish_up();
  end

  logic [47:0] ka [5];
  logic [47:0] kb [5];

  initial begin
    int na, nb;
    logic [47:0] cand;
    exp_t e;
    na = 0; nb = 0;
    ka[0] = 48'h0200_1234_0000;
    na = 1;
    for (int i = 1; i < 4000 && (na < 5 || nb < 5); i++) begin
      cand = 48'h0200_1234_0000 + 48'(i * 37);
      if (hash_bkt(cand) == hash_bkt(ka[0])) begin
        if (na < 5) begin ka[na] = cand; na++; end
      end else if (nb == 0 || hash_bkt(cand) == hash_bkt(kb[0])) begin
        if (nb < 5) begin kb[nb] = cand; nb++; end
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lk_ready && ins_ready, "R1", "readies after reset", int'(lk_ready) + int'(ins_ready), 2);
    check(!rsp_valid && !ins_done && !ins_full, "R1", "strobes after reset",
          int'(rsp_valid) + int'(ins_done) + int'(ins_full), 0);

    do_lookup(ka[0], 1'b0, 8'h00, WAYS, "R4");
    do_lookup(kb[3], 1'b0, 8'h00, WAYS, "R1");
    do_insert(ka[0], 8'h11, 1'b0, WAYS, "R5");
    do_lookup(ka[0], 1'b1, 8'h11, 1, "R3");
    do_insert(ka[1], 8'h22, 1'b0, WAYS, "R5");
    do_insert(ka[2], 8'h33, 1'b0, WAYS, "R5");
    do_insert(ka[3], 8'h44, 1'b0, WAYS, "R2");
    do_lookup(ka[3], 1'b1, 8'h44, 4, "R3");
    do_lookup(ka[2], 1'b1, 8'h33, 3, "R2");
    do_insert(ka[4], 8'h55, 1'b1, WAYS, "R7");
    do_lookup(ka[4], 1'b0, 8'h00, WAYS, "R7");
    do_lookup(ka[1], 1'b1, 8'h22, 2, "R7");
    do_insert(ka[0], 8'h66, 1'b0, 1, "R6");
    do_lookup(ka[0], 1'b1, 8'h66, 1, "R6");
    do_lookup(ka[3], 1'b1, 8'h44, 4, "R6");

    do_insert(kb[0], 8'h01, 1'b0, WAYS, "R5");
    do_insert(kb[0], 8'h02, 1'b0, 1, "R6");
    do_insert(kb[1], 8'h03, 1'b0, WAYS, "R6");
    do_insert(kb[2], 8'h04, 1'b0, WAYS, "R6");
    do_insert(kb[3], 8'h05, 1'b0, WAYS, "R6");
    do_insert(kb[4], 8'h06, 1'b1, WAYS, "R7");
    do_lookup(kb[0], 1'b1, 8'h02, 1, "R6");
    do_lookup(kb[3], 1'b1, 8'h05, 4, "R5");
    @(negedge clk);
    check(!rsp_valid, "R9", "rsp_valid after pulse", int'(rsp_valid), 0);

    @(negedge clk);
    lk_valid  = 1'b1;
    lk_key    = ka[1];
    ins_valid = 1'b1;
    ins_key   = ka[4];
    ins_data  = 8'h77;
    #1;
    check(lk_ready && !ins_ready, "R8", "lookup priority readies",
          int'(lk_ready) * 10 + int'(ins_ready), 10);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(!lk_ready && !ins_ready, "R8", "readies while busy",
          int'(lk_ready) + int'(ins_ready), 0);
    e.is_ins = 1'b0; e.flag = 1'b1; e.data = 8'h22; e.lat = 2; e.acc = cyc; e.req = "R8";
    q.push_back(e);
    wait (q.size() == 0);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    e.is_ins = 1'b1; e.flag = 1'b1; e.data = '0; e.lat = WAYS; e.acc = cyc; e.req = "R8";
    q.push_back(e);
    wait (q.size() == 0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule